// File: doc/BRIEF.md
# Byte Load Unit with Translation and Zone Fault Checks

This unit carries out an unsigned byte load addressed by a base register plus a signed 16-bit offset. In the cycle a request is presented, it forms the effective address. That address goes out to an external memory-management unit, which answers with a translation-hit flag and a no-access-zone flag, and to a byte-wide memory read port. The unit then decides between two outcomes. Either it writes the zero-extended byte to the destination register, or it raises one of two ordered exceptions. An exception writes a cause code to the exception status fields, copies the current user-mode and virtual-mode bits into their saved copies, and clears both live bits. The machine status and exception status registers live outside the block. The unit reads the live mode bits as inputs and returns the new field values with write-enable pulses.

The request side is a single-cycle strobe with no back-pressure. A request is accepted in any cycle, including every cycle of a burst. Results emerge in issue order after a fixed latency, and the block never stalls. The memory read port and the memory-management answers are combinational within the request cycle. The area-option parameter selects the latency. Values 0 and 2 give a result one cycle after the strobe. Value 1 adds a register stage and gives the result two cycles after the strobe.

Top module: `lbu_unit`

## Requirements
- R1: During a request, `eff_addr` equals `base` plus `imm` sign-extended to the data width, wrapping modulo 2^DW.
- R2: A request without a fault produces `rd_we` = 1 with `rd_data` holding the memory byte in bits 7:0 and zeros in every higher bit. `esr_we` and `msr_we` stay 0.
- R3: When `vm` = 1 and `tlb_hit` = 0, the result has `esr_we` = 1, `esr_ec` = 5'b10010, `esr_s` = 0, `diz_we` = 0 and `rd_we` = 0.
- R4: When `um` = 1, `vm` = 1, `tlb_hit` = 1 and `zone_block` = 1, the result has `esr_we` = 1, `esr_ec` = 5'b10000, `esr_s` = 0, `diz_we` = 1, `esr_diz` = 1 and `rd_we` = 0.
- R5: A translation miss takes priority over a zone block. With both present, the result is the R3 outcome, with `diz_we` = 0.
- R6: With `vm` = 0, or with `um` = 0 and `vm` = 1 and a translation hit, neither `tlb_hit` nor `zone_block` has any effect, and the load completes as in R2.
- R7: On either exception, `msr_we` = 1, `msr_ums` equals the request's `um`, `msr_vms` equals the request's `vm`, and `msr_um` and `msr_vm` are both 0. `rd_we` is never asserted together with `msr_we`.
- R8: `mem_re` is 1 only in a request cycle with no fault condition present, and is 1 in every such cycle.
- R9: `done` pulses exactly once per request, in issue order. It comes 1 cycle after `start` when AREA_OPT is 0 or 2, and 2 cycles after when AREA_OPT is 1. Back-to-back requests produce back-to-back results.
- R10: After reset, and in every cycle without `done`, all write enables (`rd_we`, `msr_we`, `esr_we`, `diz_we`) are 0. With `done`, exactly one of `rd_we` and `esr_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle per load |
| base | input | DW | Base register value |
| imm | input | IW | Signed immediate offset |
| um | input | 1 | Live user-mode bit |
| vm | input | 1 | Live virtual-mode bit |
| eff_addr | output | DW | Effective address to the MMU and memory |
| tlb_hit | input | 1 | A valid translation exists for eff_addr |
| zone_block | input | 1 | eff_addr falls in a no-access zone |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 8 | Byte read at eff_addr, same cycle |
| done | output | 1 | Result pulse |
| rd_we | output | 1 | Destination write enable |
| rd_data | output | DW | Destination write value |
| msr_we | output | 1 | Mode-bit write enable |
| msr_um | output | 1 | New user-mode bit |
| msr_vm | output | 1 | New virtual-mode bit |
| msr_ums | output | 1 | New saved user-mode bit |
| msr_vms | output | 1 | New saved virtual-mode bit |
| esr_we | output | 1 | Exception cause and S-bit write enable |
| esr_ec | output | 5 | Exception cause code |
| esr_s | output | 1 | Exception S bit |
| diz_we | output | 1 | Zone-fault flag write enable |
| esr_diz | output | 1 | Zone-fault flag value |

## Verification
The bench builds two copies on the same stimulus. One uses AREA_OPT = 1, which gives the two-cycle path with its extra register stage. The other uses AREA_OPT = 0, which gives the single-cycle path. Each copy has its own scoreboard, and each scored item carries the cycle its result is due, so running both copies exposes latency and ordering differences under back-to-back bursts. Address wrap in both directions, the miss-over-zone priority, and the mode combinations that disable the checks are all reached with a 32-bit data width and a 16-bit immediate.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  localparam logic [4:0] EC_XLATE_MISS = 5'b10010;
  localparam logic [4:0] EC_ZONE_DENY  = 5'b10000;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_ZONE  = 2'd2
  } fault_e;

endpackage

// File: rtl/lbu_agen.sv
module lbu_agen #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [DW-1:0] base,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] addr
);
  localparam int EXT = DW - IW;

  logic [DW-1:0] imm_sx;

  generate
    if (EXT > 0) begin : g_ext
      assign imm_sx = {{EXT{imm[IW-1]}}, imm};
    end else begin : g_trunc
      assign imm_sx = imm[DW-1:0];
    end
  endgenerate

  assign addr = base + imm_sx;
endmodule

// File: rtl/lbu_fault_chk.sv
module lbu_fault_chk
  import lbu_pkg::*;
(
  input  logic   um,
  input  logic   vm,
  input  logic   tlb_hit,
  input  logic   zone_block,
  output fault_e fault
);
  always_comb begin
    if (vm && !tlb_hit)                fault = FLT_MISS;
    else if (um && vm && zone_block)   fault = FLT_ZONE;
    else                               fault = FLT_NONE;
  end
endmodule

// File: rtl/lbu_result.sv
module lbu_result
  import lbu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          fire,
  input  fault_e        fault,
  input  logic          um,
  input  logic          vm,
  input  logic [7:0]    mem_byte,
  output logic          rd_we,
  output logic [DW-1:0] rd_data,
  output logic          msr_we,
  output logic          um_n,
  output logic          vm_n,
  output logic          ums_n,
  output logic          vms_n,
  output logic          esr_we,
  output logic [4:0]    ec,
  output logic          s_bit,
  output logic          diz_we,
  output logic          diz
);
  always_comb begin
    rd_we   = 1'b0;
    rd_data = '0;
    msr_we  = 1'b0;
    um_n    = 1'b0;
    vm_n    = 1'b0;
    ums_n   = 1'b0;
    vms_n   = 1'b0;
    esr_we  = 1'b0;
    ec      = '0;
    s_bit   = 1'b0;
    diz_we  = 1'b0;
    diz     = 1'b0;
    if (fire) begin
      if (fault == FLT_NONE) begin
        rd_we   = 1'b1;
        rd_data = DW'(mem_byte);
      end else begin
        msr_we = 1'b1;
        ums_n  = um;
        vms_n  = vm;
        esr_we = 1'b1;
        ec     = (fault == FLT_MISS) ? EC_XLATE_MISS : EC_ZONE_DENY;
        diz_we = (fault == FLT_ZONE);
        diz    = (fault == FLT_ZONE);
      end
    end
  end
endmodule

// File: rtl/lbu_pipe.sv
module lbu_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lbu_unit.sv
module lbu_unit
  import lbu_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IW       = 16,
  parameter int AREA_OPT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] base,
  input  logic [IW-1:0] imm,
  input  logic          um,
  input  logic          vm,
  output logic [DW-1:0] eff_addr,
  input  logic          tlb_hit,
  input  logic          zone_block,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  output logic          done,
  output logic          rd_we,
  output logic [DW-1:0] rd_data,
  output logic          msr_we,
  output logic          msr_um,
  output logic          msr_vm,
  output logic          msr_ums,
  output logic          msr_vms,
  output logic          esr_we,
  output logic [4:0]    esr_ec,
  output logic          esr_s,
  output logic          diz_we,
  output logic          esr_diz
);
  localparam int STAGES = (AREA_OPT == 1) ? 2 : 1;
  localparam int RW     = DW + 16;

  fault_e        fault;
  logic          c_rd_we, c_msr_we, c_um, c_vm, c_ums, c_vms;
  logic          c_esr_we, c_s, c_diz_we, c_diz;
  logic [DW-1:0] c_rd_data;
  logic [4:0]    c_ec;
  logic [RW-1:0] res_d, res_q;

  lbu_agen #(.DW(DW), .IW(IW)) agen_i (
    .base (base),
    .imm  (imm),
    .addr (eff_addr)
  );

  lbu_fault_chk fchk_i (
    .um         (um),
    .vm         (vm),
    .tlb_hit    (tlb_hit),
    .zone_block (zone_block),
    .fault      (fault)
  );

  assign mem_re = start && (fault == FLT_NONE);

  lbu_result #(.DW(DW)) res_i (
    .fire     (start),
    .fault    (fault),
    .um       (um),
    .vm       (vm),
    .mem_byte (mem_rdata),
    .rd_we    (c_rd_we),
    .rd_data  (c_rd_data),
    .msr_we   (c_msr_we),
    .um_n     (c_um),
    .vm_n     (c_vm),
    .ums_n    (c_ums),
    .vms_n    (c_vms),
    .esr_we   (c_esr_we),
    .ec       (c_ec),
    .s_bit    (c_s),
    .diz_we   (c_diz_we),
    .diz      (c_diz)
  );

  assign res_d = {start, c_rd_we, c_rd_data, c_msr_we, c_um, c_vm, c_ums, c_vms,
                  c_esr_we, c_ec, c_s, c_diz_we, c_diz};

  lbu_pipe #(.W(RW), .STAGES(STAGES)) pipe_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (res_d),
    .q     (res_q)
  );

  assign {done, rd_we, rd_data, msr_we, msr_um, msr_vm, msr_ums, msr_vms,
          esr_we, esr_ec, esr_s, diz_we, esr_diz} = res_q;
endmodule

// File: rtl/lbu_unit_chk.sv
module lbu_unit_chk #(
  parameter int DW       = 32,
  parameter int IW       = 16,
  parameter int AREA_OPT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] base,
  input logic [IW-1:0] imm,
  input logic          um,
  input logic          vm,
  input logic [DW-1:0] eff_addr,
  input logic          tlb_hit,
  input logic          zone_block,
  input logic          mem_re,
  input logic [7:0]    mem_rdata,
  input logic          done,
  input logic          rd_we,
  input logic [DW-1:0] rd_data,
  input logic          msr_we,
  input logic          msr_um,
  input logic          msr_vm,
  input logic          msr_ums,
  input logic          msr_vms,
  input logic          esr_we,
  input logic [4:0]    esr_ec,
  input logic          esr_s,
  input logic          diz_we,
  input logic          esr_diz
);
  assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_data[DW-1:8] == '0);

  assert_miss_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_we && !diz_we) |-> (esr_ec == 5'b10010 && !esr_s));

  assert_zone_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    diz_we |-> (esr_we && esr_ec == 5'b10000 && esr_diz && !esr_s));

  assert_checks_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !vm) |-> mem_re);

  assert_mode_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msr_we |-> (!msr_um && !msr_vm && esr_we && !rd_we));

  assert_no_fault_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (start && !(vm && !tlb_hit) && !(um && vm && zone_block)));

  generate
    if (AREA_OPT == 1) begin : g_two
      assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done);
    end else begin : g_one
      assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    end
  endgenerate

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({rd_we, esr_we}) == 1);

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(rd_we || msr_we || esr_we || diz_we));
endmodule

bind lbu_unit lbu_unit_chk #(.DW(DW), .IW(IW), .AREA_OPT(AREA_OPT)) chk_i (.*);

// File: tb/lbu_unit_tb_top.sv
`timescale 1ns/1ps
module lbu_unit_tb_top;
  localparam int DW = 32;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [DW-1:0] base = '0;
  logic [IW-1:0] imm = '0;
  logic          um = 1'b0, vm = 1'b0, tlb_hit = 1'b0, zone_block = 1'b0;

  logic [DW-1:0] s_eff_addr, f_eff_addr, s_rd_data, f_rd_data;
  logic [7:0]    s_mem_rdata, f_mem_rdata;
  logic [4:0]    s_ec, f_ec;
  logic s_mem_re, s_done, s_rd_we, s_msr_we, s_um, s_vm, s_ums, s_vms;
  logic s_esr_we, s_s, s_diz_we, s_diz;
  logic f_mem_re, f_done, f_rd_we, f_msr_we, f_um, f_vm, f_ums, f_vms;
  logic f_esr_we, f_s, f_diz_we, f_diz;

  function automatic logic [7:0] mem_model(input logic [DW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hC3;
  endfunction

  assign s_mem_rdata = mem_model(s_eff_addr);
  assign f_mem_rdata = mem_model(f_eff_addr);

  lbu_unit #(.DW(DW), .IW(IW), .AREA_OPT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .imm(imm),
    .um(um), .vm(vm), .eff_addr(s_eff_addr), .tlb_hit(tlb_hit),
    .zone_block(zone_block), .mem_re(s_mem_re), .mem_rdata(s_mem_rdata),
    .done(s_done), .rd_we(s_rd_we), .rd_data(s_rd_data), .msr_we(s_msr_we),
    .msr_um(s_um), .msr_vm(s_vm), .msr_ums(s_ums), .msr_vms(s_vms),
    .esr_we(s_esr_we), .esr_ec(s_ec), .esr_s(s_s), .diz_we(s_diz_we),
    .esr_diz(s_diz)
  );

  lbu_unit #(.DW(DW), .IW(IW), .AREA_OPT(0)) dut_fast_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .imm(imm),
    .um(um), .vm(vm), .eff_addr(f_eff_addr), .tlb_hit(tlb_hit),
    .zone_block(zone_block), .mem_re(f_mem_re), .mem_rdata(f_mem_rdata),
    .done(f_done), .rd_we(f_rd_we), .rd_data(f_rd_data), .msr_we(f_msr_we),
    .msr_um(f_um), .msr_vm(f_vm), .msr_ums(f_ums), .msr_vms(f_vms),
    .esr_we(f_esr_we), .esr_ec(f_ec), .esr_s(f_s), .diz_we(f_diz_we),
    .esr_diz(f_diz)
  );

  typedef struct {
    int            due;
    bit            exc;
    logic [4:0]    ec;
    bit            diz;
    bit            ums;
    bit            vms;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t q_slow[$];
  exp_t q_fast[$];
  exp_t e_s, e_f;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic cmp(input string tag, input exp_t e,
                     input logic rwe, input logic [DW-1:0] rdat,
                     input logic mwe, input logic mu, input logic mv,
                     input logic mus, input logic mvs, input logic ewe,
                     input logic [4:0] ec, input logic es,
                     input logic dwe, input logic dz);
    chk("R9", {tag, " done cycle"}, cyc, e.due);
    if (!e.exc) begin
      chk(e.req, {tag, " rd_we"}, rwe, 1'b1);
      chk(e.req, {tag, " rd_data"}, rdat, e.data);
      chk(e.req, {tag, " esr_we"}, ewe, 1'b0);
      chk(e.req, {tag, " msr_we"}, mwe, 1'b0);
    end else begin
      chk(e.req, {tag, " rd_we"}, rwe, 1'b0);
      chk(e.req, {tag, " esr_we"}, ewe, 1'b1);
      chk(e.req, {tag, " esr_ec"}, ec, e.ec);
      chk(e.req, {tag, " esr_s"}, es, 1'b0);
      chk(e.req, {tag, " diz_we"}, dwe, e.diz);
      if (e.diz) chk(e.req, {tag, " esr_diz"}, dz, 1'b1);
      chk("R7", {tag, " msr_we"}, mwe, 1'b1);
      chk("R7", {tag, " msr_um/vm"}, {mu, mv}, 2'b00);
      chk("R7", {tag, " msr_ums/vms"}, {mus, mvs}, {e.ums, e.vms});
    end
  endtask

  // Scoreboard monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (s_done) begin
        if (q_slow.size() == 0) chk("R9", "slow unexpected done", 1, 0);
        else begin
          e_s = q_slow.pop_front();
          cmp("slow", e_s, s_rd_we, s_rd_data, s_msr_we, s_um, s_vm, s_ums, s_vms,
              s_esr_we, s_ec, s_s, s_diz_we, s_diz);
        end
      end else if (s_rd_we || s_msr_we || s_esr_we || s_diz_we)
        chk("R10", "slow write enable without done", 1, 0);
      if (f_done) begin
        if (q_fast.size() == 0) chk("R9", "fast unexpected done", 1, 0);
        else begin
          e_f = q_fast.pop_front();
          cmp("fast", e_f, f_rd_we, f_rd_data, f_msr_we, f_um, f_vm, f_ums, f_vms,
              f_esr_we, f_ec, f_s, f_diz_we, f_diz);
        end
      end else if (f_rd_we || f_msr_we || f_esr_we || f_diz_we)
        chk("R10", "fast write enable without done", 1, 0);
    end
  end

  // Driver: applies one request and pushes the expected item
  task automatic issue(input logic [DW-1:0] b, input logic [IW-1:0] i,
                       input logic u, input logic v, input logic h, input logic z,
                       input string rq);
    logic [DW-1:0] a;
    bit miss, zone;
    exp_t e;
    @(negedge clk);
    start = 1'b1; base = b; imm = i; um = u; vm = v; tlb_hit = h; zone_block = z;
    a    = b + {{(DW-IW){i[IW-1]}}, i};
    miss = v && !h;
    zone = !miss && u && v && z;
    #1;
    chk("R1", "slow eff_addr", s_eff_addr, a);
    chk("R1", "fast eff_addr", f_eff_addr, a);
    chk("R8", "slow mem_re", s_mem_re, !(miss || zone));
    chk("R8", "fast mem_re", f_mem_re, !(miss || zone));
    e.exc  = miss || zone;
    e.ec   = miss ? 5'b10010 : 5'b10000;
    e.diz  = zone;
    e.ums  = u;
    e.vms  = v;
    e.data = {{(DW-8){1'b0}}, mem_model(a)};
    e.req  = rq;
    e.due  = cyc + 2;
    q_slow.push_back(e);
    e.due  = cyc + 1;
    q_fast.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("R9", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    string rq;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "slow outputs in reset", {s_done, s_rd_we, s_msr_we, s_esr_we, s_diz_we}, 5'b0);
    chk("R10", "fast outputs in reset", {f_done, f_rd_we, f_msr_we, f_esr_we, f_diz_we}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "slow outputs after reset", {s_done, s_rd_we, s_esr_we}, 3'b0);

    // Single requests with gaps
    issue(32'h0000_1000, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, "R6");  // vm=0: hit/zone ignored
    idle(3);
    issue(32'h0000_1000, 16'hFFF0, 1'b0, 1'b0, 1'b1, 1'b0, "R2");  // negative offset
    idle(3);
    issue(32'hFFFF_FFF0, 16'h0020, 1'b1, 1'b0, 1'b0, 1'b1, "R6");  // wrap upward, vm=0
    idle(3);
    issue(32'h0000_0004, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, "R2");  // wrap downward
    idle(3);
    issue(32'h1234_5678, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, "R3");  // miss, um=0
    idle(3);
    issue(32'h2222_0000, 16'h0042, 1'b1, 1'b1, 1'b0, 1'b1, "R5");  // miss beats zone
    idle(3);
    issue(32'h3333_0000, 16'h0100, 1'b1, 1'b1, 1'b1, 1'b1, "R4");  // zone fault
    idle(3);
    issue(32'h4444_0000, 16'h0200, 1'b0, 1'b1, 1'b1, 1'b1, "R6");  // um=0: zone ignored
    idle(3);
    issue(32'h5555_0000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0, "R2");  // both modes, clean
    idle(3);

    // Back-to-back burst mixing outcomes (R9 ordering)
    issue(32'h0000_0100, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
    issue(32'h0000_0200, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    issue(32'h0000_0300, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    issue(32'h0000_0400, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    issue(32'h0000_0500, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    idle(4);

    // Pseudo-random stream
    lf = 32'hACE1_2345;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[4] && !lf[5])             rq = (lf[6] && lf[7]) ? "R5" : "R3";
      else if (lf[4] && lf[6] && lf[7]) rq = "R4";
      else if (lf[4])                  rq = "R6";
      else                             rq = "R2";
      // fields: vm=lf[4], hit=lf[5], um=lf[6], zone=lf[7]
      issue({lf[15:0], lf[31:16]}, lf[23:8], lf[6], lf[4], lf[5], lf[7], rq);
      if (lf[9] && lf[10]) idle(1);
    end
    idle(6);
    chk("R9", "slow items left unfinished", q_slow.size(), 0);
    chk("R9", "fast items left unfinished", q_fast.size(), 0);
    finish_run();
  end
endmodule